// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Shift Unit with Sign, Zero, Carry and Overflow Flags

This unit serves the execute stage of an accumulator-style processor. Each request carries an operation code, two operands (the accumulator-side operand `in_a` and the memory-side operand `in_m`), and the processor's current carry. The unit computes a data result, four condition flags, and a per-flag write-enable mask. The mask tells the caller which flags the operation changes. The caller merges the new flags into its status register under the mask and keeps every flag whose mask bit is clear.

Requests enter on a valid/ready handshake and leave one cycle later on a second valid/ready handshake, through a single register stage. A request is accepted on a rising edge when `in_valid` and `in_ready` are both high. A completed result stays on the output, unchanged, until the consumer raises `out_ready`. While the output holds a result that has not been taken, `in_ready` is low. When the consumer takes a result, a new request can be accepted on the same edge. Decimal arithmetic, register storage and memory write-back are outside the unit.

Opcode encoding (`in_op`): 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 compare, 6 shift left, 7 logical shift right, 8 rotate left, 9 rotate right, 10 increment, 11 decrement, 12 bit-test, 13 load, 14 and 15 reserved. Flag vectors are packed as bit 3 = N (sign), bit 2 = Z (zero), bit 1 = C (carry), bit 0 = V (overflow). The mask uses the same packing.

Top module: `nzcv_alu`

## Requirements
- R1: Add (op 0) returns the low 8 bits of A + M + carry-in. It sets C when the 9-bit sum exceeds 255 and writes all four flags (mask 4'b1111).
- R2: On add and subtract, V is set exactly when the result's bit 7 differs both from A's bit 7 and from bit 7 of the operand actually added (M for add, ~M for subtract).
- R3: Subtract (op 1) returns A + ~M + carry-in, where carry-in means "no borrow". C is the carry out of that sum, and the mask is 4'b1111.
- R4: Compare (op 5) ignores carry-in. It sets C when A >= M unsigned, sets Z when A == M, and sets N from bit 7 of A - M. The result output equals A, and the mask is 4'b1110.
- R5: Shift left (op 6) moves A[7] into C and shifts in 0. Rotate left (op 8) moves A[7] into C and shifts in the old carry. Both have mask 4'b1110.
- R6: Logical shift right (op 7) moves A[0] into C, shifts in 0, and forces N to 0. The mask is 4'b1110.
- R7: Rotate right (op 9) moves A[0] into C and puts the old carry into bit 7. The mask is 4'b1110.
- R8: Bit-test (op 12) sets Z when (A AND M) is zero, copies M[7] into N and M[6] into V, and returns A as the result. The mask is 4'b1101.
- R9: The logical operations AND/OR/XOR (ops 2-4) combine A with M. Increment (op 10) computes A+1 modulo 256 and decrement (op 11) computes A-1 modulo 256. Load (op 13) returns M. These operations write only N and Z (mask 4'b1100). N is result bit 7, and Z is set when the result is zero.
- R10: Every flag bit whose mask bit is 0 reads 0. Reserved codes 14 and 15 return A with mask 4'b0000.
- R11: `in_ready` equals `!out_valid || out_ready`. An accepted request appears on the output after the next rising edge. An output that is not taken holds stable.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | Accumulator-side operand |
| in_m | input | 8 | Memory-side operand |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Data result |
| out_flags | output | 4 | New N,Z,C,V values (zero where not written) |
| out_flag_we | output | 4 | Per-flag write enable, same packing |

## Verification
The bench builds the unit with the default width of 8. This lets the sign boundary (0x7F/0x80), the wrap values 0x00 and 0xFF, and the bit-6/bit-7 pair used by bit-test all be driven directly. Each of these cases has hand-computed expected values. Beyond the anchored cases, the bench walks all opcodes across a grid of edge operands with both carry values. It also runs a back-pressure sequence that stalls the consumer while a second request waits at the input.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_INC  = 4'd10,
    OP_DEC  = 4'd11,
    OP_BIT  = 4'd12,
    OP_LOAD = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  localparam int FLAG_COUNT = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef logic [FLAG_COUNT-1:0] flag_vec_t;

  localparam flag_vec_t WE_ALL  = 4'b1111;
  localparam flag_vec_t WE_NZC  = 4'b1110;
  localparam flag_vec_t WE_NZV  = 4'b1101;
  localparam flag_vec_t WE_NZ   = 4'b1100;
  localparam flag_vec_t WE_NONE = 4'b0000;
endpackage

// File: rtl/nzcv_alu_adder.sv
module nzcv_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  assign full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign sum  = full[MSB:0];
  assign cout = full[WIDTH];
  // signed overflow: result sign disagrees with both addend signs
  assign ovf  = (a[MSB] != sum[MSB]) && (b[MSB] != sum[MSB]);
endmodule

// File: rtl/nzcv_alu_shifter.sv
module nzcv_alu_shifter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val,
  input  logic             cin,
  input  logic             right,
  input  logic             rotate,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int MSB = WIDTH - 1;

  logic fill;

  assign fill = rotate ? cin : 1'b0;

  always_comb begin
    if (right) begin
      res  = {fill, val[MSB:1]};
      cout = val[0];
    end else begin
      res  = {val[MSB-1:0], fill};
      cout = val[MSB];
    end
  end
endmodule

// File: rtl/nzcv_alu_flagmask.sv
module nzcv_alu_flagmask
  import nzcv_alu_pkg::*;
(
  input  alu_op_e   op,
  output flag_vec_t we
);
  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:                         we = WE_ALL;
      OP_CMP, OP_SHL, OP_SHR, OP_ROL, OP_ROR: we = WE_NZC;
      OP_BIT:                                 we = WE_NZV;
      OP_AND, OP_OR, OP_XOR,
      OP_INC, OP_DEC, OP_LOAD:                we = WE_NZ;
      default:                                we = WE_NONE;
    endcase
  end
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_m,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic [3:0]       out_flags,
  output logic [3:0]       out_flag_we
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  // main adder: add, subtract, compare share one carry chain
  logic             inv_m;
  logic [WIDTH-1:0] arith_b;
  logic             arith_cin;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_c;
  logic             arith_v;

  assign inv_m     = (op == OP_SUB) || (op == OP_CMP);
  assign arith_b   = inv_m ? ~in_m : in_m;
  assign arith_cin = (op == OP_CMP) ? 1'b1 : in_carry;

  nzcv_alu_adder #(.WIDTH(WIDTH)) u_arith (
    .a    (in_a),
    .b    (arith_b),
    .cin  (arith_cin),
    .sum  (arith_sum),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  // step adder: increment / decrement of A
  logic [WIDTH-1:0] step_b;
  logic             step_cin;
  logic [WIDTH-1:0] step_sum;
  logic             step_c_unused;
  logic             step_v_unused;

  assign step_b   = (op == OP_DEC) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  assign step_cin = (op == OP_INC);

  nzcv_alu_adder #(.WIDTH(WIDTH)) u_step (
    .a    (in_a),
    .b    (step_b),
    .cin  (step_cin),
    .sum  (step_sum),
    .cout (step_c_unused),
    .ovf  (step_v_unused)
  );

  // shifter
  logic             sh_right;
  logic             sh_rotate;
  logic [WIDTH-1:0] sh_res;
  logic             sh_c;

  assign sh_right  = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rotate = (op == OP_ROL) || (op == OP_ROR);

  nzcv_alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .val    (in_a),
    .cin    (in_carry),
    .right  (sh_right),
    .rotate (sh_rotate),
    .res    (sh_res),
    .cout   (sh_c)
  );

  flag_vec_t we_next;

  nzcv_alu_flagmask u_mask (
    .op (op),
    .we (we_next)
  );

  // result and raw flag selection
  logic [WIDTH-1:0] res_next;
  logic             n_raw;
  logic             z_raw;
  logic             c_raw;
  logic             v_raw;
  flag_vec_t        flags_next;

  always_comb begin
    res_next = in_a;
    c_raw    = 1'b0;
    v_raw    = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_next = arith_sum;
        c_raw    = arith_c;
        v_raw    = arith_v;
      end
      OP_AND:  res_next = in_a & in_m;
      OP_OR:   res_next = in_a | in_m;
      OP_XOR:  res_next = in_a ^ in_m;
      OP_CMP:  c_raw    = arith_c;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_next = sh_res;
        c_raw    = sh_c;
      end
      OP_INC, OP_DEC: res_next = step_sum;
      OP_BIT:  v_raw    = in_m[MSB-1];
      OP_LOAD: res_next = in_m;
      default: res_next = in_a;
    endcase

    n_raw = res_next[MSB];
    z_raw = (res_next == '0);
    if (op == OP_CMP) begin
      n_raw = arith_sum[MSB];
      z_raw = (arith_sum == '0);
    end else if (op == OP_BIT) begin
      n_raw = in_m[MSB];
      z_raw = ((in_a & in_m) == '0);
    end else if (op == OP_SHR) begin
      n_raw = 1'b0;
    end

    flags_next = {n_raw, z_raw, c_raw, v_raw} & we_next;
  end

  // single output register stage
  logic             valid_q;
  logic [WIDTH-1:0] res_q;
  flag_vec_t        flags_q;
  flag_vec_t        we_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      we_q    <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_next;
        flags_q <= flags_next;
        we_q    <= we_next;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_result  = res_q;
  assign out_flags   = flags_q;
  assign out_flag_we = we_q;
endmodule

// File: rtl/nzcv_alu_checker.sv
module nzcv_alu_checker
  import nzcv_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_m,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [3:0]       out_flags,
  input logic [3:0]       out_flag_we
);
  logic take;
  assign take = in_valid && in_ready;

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_flag_we)); // R11
  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R11
  AST_UNWRITTEN_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & ~out_flag_we) == 4'b0000)); // R10
  AST_SHR_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == OP_SHR) |=> !out_flags[FN]); // R6
  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == OP_CMP) |=> out_result == $past(in_a)); // R4
  AST_BIT_COPIES_M: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_op == OP_BIT) |=> (out_flags[FN] == $past(in_m[WIDTH-1])) && (out_flags[FV] == $past(in_m[WIDTH-2]))); // R8
endmodule

bind nzcv_alu nzcv_alu_checker #(.WIDTH(WIDTH)) u_nzcv_alu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_a        (in_a),
  .in_m        (in_m),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_flags   (out_flags),
  .out_flag_we (out_flag_we)
);

// File: tb/nzcv_alu_bench.sv
module nzcv_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = 4'd0;
  logic [7:0] in_a = 8'h00;
  logic [7:0] in_m = 8'h00;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [3:0] out_flags;
  logic [3:0] out_flag_we;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nzcv_alu #(.WIDTH(8)) u_nzcv_alu (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_a, .in_m, .in_carry,
    .out_valid, .out_ready, .out_result, .out_flags, .out_flag_we
  );

  // expected {result, flags, mask} built from the requirements
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] m, input logic c);
    logic [8:0] s;
    logic [7:0] r, d;
    logic n, z, cy, v;
    logic [3:0] we;
    r = a; cy = 1'b0; v = 1'b0; we = 4'b0000; d = a - m;
    case (op)
      4'd0: begin s = {1'b0,a} + {1'b0,m} + {8'd0,c}; r = s[7:0]; cy = s[8];
                  v = (a[7] != r[7]) && (m[7] != r[7]); we = 4'b1111; end
      4'd1: begin s = {1'b0,a} + {1'b0,~m} + {8'd0,c}; r = s[7:0]; cy = s[8];
                  v = (a[7] != r[7]) && (~m[7] != r[7]); we = 4'b1111; end
      4'd2: begin r = a & m; we = 4'b1100; end
      4'd3: begin r = a | m; we = 4'b1100; end
      4'd4: begin r = a ^ m; we = 4'b1100; end
      4'd5: begin cy = (a >= m); we = 4'b1110; end
      4'd6: begin r = {a[6:0], 1'b0}; cy = a[7]; we = 4'b1110; end
      4'd7: begin r = {1'b0, a[7:1]}; cy = a[0]; we = 4'b1110; end
      4'd8: begin r = {a[6:0], c}; cy = a[7]; we = 4'b1110; end
      4'd9: begin r = {c, a[7:1]}; cy = a[0]; we = 4'b1110; end
      4'd10: begin r = a + 8'd1; we = 4'b1100; end
      4'd11: begin r = a - 8'd1; we = 4'b1100; end
      4'd12: begin v = m[6]; we = 4'b1101; end
      4'd13: begin r = m; we = 4'b1100; end
      default: we = 4'b0000;
    endcase
    n = r[7]; z = (r == 8'h00);
    if (op == 4'd5) begin n = d[7]; z = (a == m); end
    if (op == 4'd12) begin n = m[7]; z = ((a & m) == 8'h00); end
    return {r, {n, z, cy, v} & we, we};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got res=%h flags=%b we=%b expected res=%h flags=%b we=%b",
               tag, got[15:8], got[7:4], got[3:0], exp[15:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m, input logic c);
    @(negedge clk);
    in_op = op; in_a = a; in_m = m; in_carry = c; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic anchor(input string tag, input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic c, input logic [7:0] er, input logic [3:0] ef, input logic [3:0] ew);
    issue(op, a, m, c);
    check(tag, {out_result, out_flags, out_flag_we}, {er, ef, ew});
  endtask

  task automatic sweep(input string tag, input logic [3:0] op);
    logic [7:0] pts [6] = '{8'h00, 8'h01, 8'h40, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 2; k++) begin
          issue(op, pts[i], pts[j], k[0]);
          check(tag, {out_result, out_flags, out_flag_we}, model(op, pts[i], pts[j], k[0]));
        end
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 got out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_add;
    anchor("R1 0xFF+0x01", 4'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 4'b0110, 4'b1111);
    anchor("R1 carry-in", 4'd0, 8'h10, 8'h20, 1'b1, 8'h31, 4'b0000, 4'b1111);
    anchor("R2 pos overflow", 4'd0, 8'h50, 8'h50, 1'b0, 8'hA0, 4'b1001, 4'b1111);
    anchor("R2 neg overflow", 4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 4'b0111, 4'b1111);
    sweep("R1 sweep", 4'd0);
  endtask

  task automatic t_sub;
    anchor("R3 no borrow", 4'd1, 8'h50, 8'h30, 1'b1, 8'h20, 4'b0010, 4'b1111);
    anchor("R3 borrow", 4'd1, 8'h30, 8'h50, 1'b1, 8'hE0, 4'b1000, 4'b1111);
    anchor("R3 borrow-in", 4'd1, 8'h05, 8'h05, 1'b0, 8'hFF, 4'b1000, 4'b1111);
    anchor("R2 sub overflow", 4'd1, 8'h80, 8'h01, 1'b1, 8'h7F, 4'b0011, 4'b1111);
    sweep("R3 sweep", 4'd1);
  endtask

  task automatic t_cmp;
    anchor("R4 equal", 4'd5, 8'h42, 8'h42, 1'b0, 8'h42, 4'b0110, 4'b1110);
    anchor("R4 greater", 4'd5, 8'h90, 8'h10, 1'b0, 8'h90, 4'b1010, 4'b1110);
    anchor("R4 less", 4'd5, 8'h10, 8'h20, 1'b1, 8'h10, 4'b1000, 4'b1110);
    sweep("R4 sweep", 4'd5);
  endtask

  task automatic t_shift;
    anchor("R5 shl", 4'd6, 8'h81, 8'h00, 1'b1, 8'h02, 4'b0010, 4'b1110);
    anchor("R5 rol", 4'd8, 8'h40, 8'h00, 1'b1, 8'h81, 4'b1000, 4'b1110);
    anchor("R6 shr to zero", 4'd7, 8'h01, 8'h00, 1'b1, 8'h00, 4'b0110, 4'b1110);
    anchor("R7 ror", 4'd9, 8'h02, 8'h00, 1'b1, 8'h81, 4'b1000, 4'b1110);
    sweep("R5 shl sweep", 4'd6);
    sweep("R6 shr sweep", 4'd7);
    sweep("R5 rol sweep", 4'd8);
    sweep("R7 ror sweep", 4'd9);
  endtask

  task automatic t_bit;
    anchor("R8 bits 7,6", 4'd12, 8'h01, 8'hC0, 1'b0, 8'h01, 4'b1101, 4'b1101);
    anchor("R8 overlap", 4'd12, 8'h0F, 8'h01, 1'b1, 8'h0F, 4'b0000, 4'b1101);
    sweep("R8 sweep", 4'd12);
  endtask

  task automatic t_logic;
    anchor("R9 inc wrap", 4'd10, 8'hFF, 8'h00, 1'b1, 8'h00, 4'b0100, 4'b1100);
    anchor("R9 dec wrap", 4'd11, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b1000, 4'b1100);
    anchor("R9 load", 4'd13, 8'h11, 8'h80, 1'b0, 8'h80, 4'b1000, 4'b1100);
    anchor("R9 xor", 4'd4, 8'hF0, 8'hF0, 1'b1, 8'h00, 4'b0100, 4'b1100);
    for (int op = 2; op <= 4; op++) sweep("R9 logic sweep", op[3:0]);
    sweep("R9 inc sweep", 4'd10);
    sweep("R9 dec sweep", 4'd11);
  endtask

  task automatic t_reserved;
    anchor("R10 reserved 14", 4'd14, 8'h80, 8'h00, 1'b1, 8'h80, 4'b0000, 4'b0000);
    anchor("R10 reserved 15", 4'd15, 8'h00, 8'hFF, 1'b1, 8'h00, 4'b0000, 4'b0000);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    issue(4'd0, 8'h01, 8'h01, 1'b0);
    checks++;
    if (out_valid !== 1'b1 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R11 stall got out_valid=%b in_ready=%b expected 1 0", out_valid, in_ready);
    end
    in_op = 4'd4; in_a = 8'hF0; in_m = 8'h0F; in_valid = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R11 held", {out_result, out_flags, out_flag_we}, {8'h02, 4'b0000, 4'b1111});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next after release", {out_result, out_flags, out_flag_we}, {8'hFF, 4'b1000, 4'b1100});
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 drain got out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_shift();
    t_bit();
    t_logic();
    t_reserved();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule